// File: doc/BRIEF.md
# AXI4 Write Burst Strobe Generator

This block turns one write request into a single AXI4 INCR write burst. A request gives a start address, a byte count, a transfer size (log2 of the bytes per beat) and a ceiling on the beat count. The block issues the write address once, then takes bytes one at a time from a byte-stream input. It packs each byte into the bus lane that matches its address and sends a W beat whenever the beat window is full or the bytes run out. It then accepts the write response and reports it on a one-cycle done pulse.

The requested length is only an upper limit. The burst is cut to the beats that the supplied bytes actually need. Lanes before the start offset and lanes past the last byte carry no strobe. Because of this, the slave never receives zero-filled trailing bytes with active strobes. A request with no bytes, or with a size wider than the bus, is refused without any bus activity.

Top module: `wr_strobe_burst`

## Requirements
- R1: A request is taken when `req_valid` and `req_ready` are both high. The address channel then presents `awaddr` = request address, `awsize` = request size and `awburst` = 2'b01 (INCR). `awvalid` and the address fields stay unchanged until `awready`. Exactly one address handshake occurs per accepted request.
- R2: With bytes per beat B = 2^size and offset o = address mod B, `awlen` = min(max_len, ceil((o + count) / B) - 1).
- R3: Each beat strobes only lanes inside the aligned B-byte window that holds that beat's address. The lane of a byte is its address mod (DATA_W/8), and no beat has more than B strobe bits set.
- R4: On the first beat, the lanes below the start address carry no strobe (front padding).
- R5: On the final beat, only the lanes of the remaining bytes are strobed. Example: 0x100, 20 bytes, size 3, max_len 7 gives 3 beats, and the last strobe is 8'h0F.
- R6: The block consumes exactly min(count, (awlen+1)·B - o) stream bytes and leaves the rest in the stream. Byte i goes to address start+i, in lane (start+i) mod (DATA_W/8). Lanes with no strobe carry zero data.
- R7: Exactly `awlen`+1 W beats are sent, and `wlast` is high on the final beat only.
- R8: While `wvalid` is high and `wready` is low, `wvalid`, `wdata`, `wstrb` and `wlast` hold their values.
- R9: `bready` rises only after the last W handshake and stays high until `bvalid`. A one-cycle `done` pulse follows, with `done_resp` = BRESP (non-OKAY passed through) and `done_rejected` = 0.
- R10: A request whose count is zero, or whose size exceeds log2(DATA_W/8), gives a `done` pulse with `done_rejected` = 1. It produces no address beat, no W beat and no stream byte consumption.
- R11: After reset, `req_ready` = 1 and `awvalid`, `wvalid`, `bready`, `s_ready` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | ADDR_W | Start byte address |
| req_bytes | input | CNT_W | Number of bytes to write |
| req_size | input | 3 | log2 of bytes per beat |
| req_max_len | input | LEN_W | Beat ceiling minus one |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte taken |
| s_data | input | 8 | Stream byte |
| awvalid | output | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| awaddr | output | ADDR_W | Burst start address |
| awlen | output | LEN_W | Beats minus one |
| awsize | output | 3 | Transfer size |
| awburst | output | 2 | Burst type, always INCR |
| wvalid | output | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Byte strobes |
| wlast | output | 1 | Final beat |
| bvalid | input | 1 | Response valid |
| bready | output | 1 | Response ready |
| bresp | input | 2 | Response code |
| done | output | 1 | One-cycle completion pulse |
| done_resp | output | 2 | Response of the finished burst |
| done_rejected | output | 1 | Request refused without bus activity |

## Verification
A wrong byte budget or beat counter shows up at the ports within the burst it corrupts. Such a fault produces a beat count that differs from `awlen`, a `wlast` that comes early or late, or a count of stream bytes consumed that is too high or too low. A wrong lane pointer shows up on the very next W beat as a strobe or data byte in the wrong lane, or as strobes outside the size window. The scenarios cover:
- aligned, unaligned and narrow sizes;
- truncation by the beat ceiling;
- a 256-beat burst;
- backpressure on every channel;
- refused requests.

// File: rtl/wsb_pkg.sv
`timescale 1ns/1ps
package wsb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_FILL, ST_SEND, ST_RESP
  } wsb_state_e;

  localparam logic [1:0] BURST_INCR = 2'b01;
endpackage

// File: rtl/wsb_planner.sv
`timescale 1ns/1ps
// Combinational burst sizing: beats, AWLEN, byte budget and refusal.
module wsb_planner #(
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 8,
  parameter int LANE_W = 3
) (
  input  logic [LANE_W-1:0] addr_lo,
  input  logic [CNT_W-1:0]  bytes,
  input  logic [2:0]        size,
  input  logic [LEN_W-1:0]  max_len,
  output logic              reject,
  output logic [LEN_W-1:0]  len,
  output logic [CNT_W-1:0]  wr_bytes
);
  localparam int EW = CNT_W + 2;

  logic [EW-1:0] one, mask, off, bytes_x, need, ceil_beats, beats, cap;

  always_comb begin
    one        = EW'(1);
    mask       = (one << size) - one;
    off        = EW'(addr_lo) & mask;
    bytes_x    = EW'(bytes);
    need       = (off + bytes_x + mask) >> size;
    ceil_beats = EW'(max_len) + one;
    beats      = (need < ceil_beats) ? need : ceil_beats;
    cap        = (beats << size) - off;
    wr_bytes   = (bytes_x < cap) ? bytes : CNT_W'(cap);
    len        = LEN_W'(beats - one);
    reject     = (bytes == '0) || (size > 3'(LANE_W));
  end
endmodule

// File: rtl/wsb_packer.sv
`timescale 1ns/1ps
// Per-lane data/strobe registers filled one byte at a time.
module wsb_packer #(
  parameter int DATA_W = 64,
  parameter int STRB_W = DATA_W / 8,
  parameter int LANE_W = $clog2(STRB_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              load,
  input  logic [LANE_W-1:0] lane,
  input  logic [7:0]        byte_in,
  output logic [DATA_W-1:0] data_out,
  output logic [STRB_W-1:0] strb_out
);
  for (genvar g = 0; g < STRB_W; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clear) begin
        data_out[g*8 +: 8] <= 8'h00;
        strb_out[g]        <= 1'b0;
      end else if (load && lane == LANE_W'(g)) begin
        data_out[g*8 +: 8] <= byte_in;
        strb_out[g]        <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wr_strobe_burst.sv
`timescale 1ns/1ps
module wr_strobe_burst
  import wsb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int CNT_W  = 16,
  parameter int LEN_W  = 8,
  localparam int STRB_W = DATA_W / 8,
  localparam int LANE_W = $clog2(STRB_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [CNT_W-1:0]  req_bytes,
  input  logic [2:0]        req_size,
  input  logic [LEN_W-1:0]  req_max_len,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [7:0]        s_data,
  output logic              awvalid,
  input  logic              awready,
  output logic [ADDR_W-1:0] awaddr,
  output logic [LEN_W-1:0]  awlen,
  output logic [2:0]        awsize,
  output logic [1:0]        awburst,
  output logic              wvalid,
  input  logic              wready,
  output logic [DATA_W-1:0] wdata,
  output logic [STRB_W-1:0] wstrb,
  output logic              wlast,
  input  logic              bvalid,
  output logic              bready,
  input  logic [1:0]        bresp,
  output logic              done,
  output logic [1:0]        done_resp,
  output logic              done_rejected
);
  wsb_state_e        state;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  left;
  logic [LEN_W-1:0]  beat_idx;
  logic [ADDR_W-1:0] win_mask;
  logic              beat_end, take, w_clear;
  logic              plan_reject;
  logic [LEN_W-1:0]  plan_len;
  logic [CNT_W-1:0]  plan_bytes;

  wsb_planner #(.CNT_W(CNT_W), .LEN_W(LEN_W), .LANE_W(LANE_W)) u_plan (
    .addr_lo (req_addr[LANE_W-1:0]),
    .bytes   (req_bytes),
    .size    (req_size),
    .max_len (req_max_len),
    .reject  (plan_reject),
    .len     (plan_len),
    .wr_bytes(plan_bytes)
  );

  assign req_ready = (state == ST_IDLE);
  assign s_ready   = (state == ST_FILL);
  assign awburst   = BURST_INCR;
  assign take      = s_ready && s_valid;
  assign w_clear   = (state == ST_SEND) && wready;
  assign win_mask  = (ADDR_W'(1) << awsize) - ADDR_W'(1);
  assign beat_end  = ((cur_addr & win_mask) == win_mask) || (left == CNT_W'(1));

  wsb_packer #(.DATA_W(DATA_W), .STRB_W(STRB_W), .LANE_W(LANE_W)) u_pack (
    .clk     (clk),
    .rst     (rst),
    .clear   (w_clear),
    .load    (take),
    .lane    (cur_addr[LANE_W-1:0]),
    .byte_in (s_data),
    .data_out(wdata),
    .strb_out(wstrb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      cur_addr      <= '0;
      left          <= '0;
      beat_idx      <= '0;
      awvalid       <= 1'b0;
      awaddr        <= '0;
      awlen         <= '0;
      awsize        <= '0;
      wvalid        <= 1'b0;
      wlast         <= 1'b0;
      bready        <= 1'b0;
      done          <= 1'b0;
      done_resp     <= 2'b00;
      done_rejected <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          if (plan_reject) begin
            done          <= 1'b1;
            done_rejected <= 1'b1;
            done_resp     <= 2'b00;
          end else begin
            awvalid  <= 1'b1;
            awaddr   <= req_addr;
            awlen    <= plan_len;
            awsize   <= req_size;
            cur_addr <= req_addr;
            left     <= plan_bytes;
            beat_idx <= '0;
            state    <= ST_ADDR;
          end
        end
        ST_ADDR: if (awready) begin
          awvalid <= 1'b0;
          state   <= ST_FILL;
        end
        ST_FILL: if (s_valid) begin
          cur_addr <= cur_addr + ADDR_W'(1);
          left     <= left - CNT_W'(1);
          if (beat_end) begin
            wvalid <= 1'b1;
            wlast  <= (beat_idx == awlen);
            state  <= ST_SEND;
          end
        end
        ST_SEND: if (wready) begin
          wvalid <= 1'b0;
          wlast  <= 1'b0;
          if (wlast) begin
            bready <= 1'b1;
            state  <= ST_RESP;
          end else begin
            beat_idx <= beat_idx + LEN_W'(1);
            state    <= ST_FILL;
          end
        end
        ST_RESP: if (bvalid) begin
          bready        <= 1'b0;
          done          <= 1'b1;
          done_resp     <= bresp;
          done_rejected <= 1'b0;
          state         <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1
  aw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    awvalid && !awready |=> awvalid && $stable(awaddr) && $stable(awlen) && $stable(awsize));
  // R8
  w_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wvalid && !wready |=> wvalid && $stable(wdata) && $stable(wstrb) && $stable(wlast));
  // R3
  strb_window_chk: assert property (@(posedge clk) disable iff (rst)
    wvalid |-> (wstrb != '0) && ($countones(wstrb) <= (32'd1 << awsize)));
  // R7
  last_budget_chk: assert property (@(posedge clk) disable iff (rst)
    wvalid |-> (wlast == (left == '0)));
  // R6
  stream_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(s_ready && (wvalid || awvalid || bready)));
  // R9
  bready_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bready) |-> $past(wvalid && wready && wlast));
  // R10
  reject_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done && done_rejected |-> !awvalid && !wvalid && !bready);
endmodule

// File: tb/wr_strobe_burst_tb.sv
`timescale 1ns/1ps
module wr_strobe_burst_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_bytes = '0;
  logic [2:0]  req_size = '0;
  logic [7:0]  req_max_len = '0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic awready = 1'b0, wready = 1'b0, bvalid = 1'b0;
  logic [1:0] bresp = 2'b00;
  logic req_ready, s_ready, awvalid, wvalid, wlast, bready, done, done_rejected;
  logic [31:0] awaddr;
  logic [7:0]  awlen;
  logic [2:0]  awsize;
  logic [1:0]  awburst, done_resp;
  logic [63:0] wdata;
  logic [7:0]  wstrb;

  int errors = 0;
  int checks = 0;

  logic [7:0]  exp_strb [0:255];
  logic [63:0] exp_data [0:255];
  logic [7:0]  got_strb [0:255];
  logic [63:0] got_data [0:255];
  logic        got_last [0:255];

  always #5 clk = ~clk;

  wr_strobe_burst u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_bytes(req_bytes), .req_size(req_size), .req_max_len(req_max_len),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .awvalid(awvalid), .awready(awready), .awaddr(awaddr), .awlen(awlen),
    .awsize(awsize), .awburst(awburst),
    .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb), .wlast(wlast),
    .bvalid(bvalid), .bready(bready), .bresp(bresp),
    .done(done), .done_resp(done_resp), .done_rejected(done_rejected)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 7 + seed) & 8'hff);
  endfunction

  task automatic run(input string name, input logic [31:0] addr, input int bytes,
                     input int size, input int max_len, input bit stall, input bit gaps,
                     input logic [1:0] resp, input bit exp_reject, input int seed);
    int bpb, off, need, beats, wr;
    int sidx = 0, nb = 0, aw_cnt = 0, bdelay = 0, cyc = 0;
    bit pending = 0, saw_last = 0, bsent = 0, bclear = 0, fin = 0, held = 0;
    logic [31:0] aw_a = '0;
    logic [7:0]  aw_l = '0;
    logic [2:0]  aw_s = '0;
    logic [1:0]  aw_b = '0;
    logic [63:0] hd = '0;
    logic [7:0]  hs = '0;
    logic [1:0]  d_resp = '0;
    logic        d_rej = 0;

    bpb   = 1 << size;
    off   = int'(addr) % bpb;
    need  = (off + bytes + bpb - 1) / bpb;
    beats = (need < max_len + 1) ? need : max_len + 1;
    wr    = (bytes < beats * bpb - off) ? bytes : beats * bpb - off;
    for (int b = 0; b < 256; b++) begin exp_strb[b] = '0; exp_data[b] = '0; end
    if (!exp_reject)
      for (int i = 0; i < wr; i++) begin
        int a, b, ln;
        a  = int'(addr) + i;
        b  = (off + i) / bpb;
        ln = a % 8;
        exp_strb[b][ln] = 1'b1;
        exp_data[b][ln*8 +: 8] = pat(i, seed);
      end

    @(negedge clk);
    req_valid = 1; req_addr = addr; req_bytes = 16'(bytes);
    req_size = 3'(size); req_max_len = 8'(max_len);
    while (!fin && cyc < 20000) begin
      if (pending) req_valid = 0;
      if (req_valid && req_ready) pending = 1;
      awready = stall ? (cyc % 3 == 2) : 1'b1;
      if (awvalid && awready) begin
        aw_cnt++; aw_a = awaddr; aw_l = awlen; aw_s = awsize; aw_b = awburst;
      end
      if (held) begin
        chk(wvalid && wdata == hd && wstrb == hs, "R8 hold under stall", longint'(wstrb), longint'(hs));
        held = 0;
      end
      wready = stall ? (cyc % 2 == 0) : 1'b1;
      if (wvalid && !wready) begin held = 1; hd = wdata; hs = wstrb; end
      if (wvalid && wready) begin
        if (nb < 256) begin
          got_strb[nb] = wstrb; got_data[nb] = wdata; got_last[nb] = wlast;
        end
        nb++;
        if (wlast) begin saw_last = 1; bdelay = stall ? 3 : 1; end
      end
      if (bclear) begin bvalid = 0; bclear = 0; end
      else if (saw_last && !bsent) begin
        if (bdelay > 0) bdelay--;
        else begin bvalid = 1; bresp = resp; end
      end
      if (bvalid && bready) begin bclear = 1; bsent = 1; end
      s_valid = gaps ? (cyc % 4 != 1) : 1'b1;
      s_data  = pat(sidx, seed);
      if (s_valid && s_ready) sidx++;
      if (done) begin fin = 1; d_resp = done_resp; d_rej = done_rejected; end
      else begin @(negedge clk); cyc++; end
    end
    s_valid = 0; bvalid = 0; awready = 0; wready = 0; req_valid = 0;
    if (!fin) chk(0, {"R9 timeout in ", name}, cyc, 0);
    @(negedge clk);
    chk(done == 0, "R9 done is one cycle", done, 0);

    if (exp_reject) begin
      chk(d_rej == 1, "R10 rejected flag", d_rej, 1);
      chk(aw_cnt == 0 && nb == 0, "R10 no bus beats", aw_cnt + nb, 0);
      chk(sidx == 0, "R10 no stream bytes", sidx, 0);
    end else begin
      chk(aw_cnt == 1, "R1 one address beat", aw_cnt, 1);
      chk(aw_a == addr && aw_s == 3'(size) && aw_b == 2'b01, "R1 address fields",
          longint'(aw_a), longint'(addr));
      chk(aw_l == 8'(beats - 1), "R2 awlen", aw_l, beats - 1);
      chk(nb == beats, "R7 beat count", nb, beats);
      for (int b = 0; b < beats && b < nb; b++) begin
        chk(got_strb[b] == exp_strb[b],
            (b == 0) ? "R4 first strobe" : (b == beats - 1) ? "R5 last strobe" : "R3 strobe",
            longint'(got_strb[b]), longint'(exp_strb[b]));
        chk(got_data[b] == exp_data[b], "R6 lane data", longint'(got_data[b]), longint'(exp_data[b]));
        chk(got_last[b] == (b == beats - 1), "R7 wlast position", got_last[b], b == beats - 1);
      end
      chk(sidx == wr, "R6 stream bytes consumed", sidx, wr);
      chk(d_resp == resp && d_rej == 0, "R9 done response", d_resp, resp);
    end
  endtask

  task automatic t_reset;
    chk(req_ready && !awvalid && !wvalid && !bready && !s_ready && !done,
        "R11 reset state", {req_ready, awvalid, wvalid, bready, s_ready, done}, 6'b100000);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    t_reset();
    // R5 example: 20 bytes, size 3, ceiling 8 beats
    run("aligned_example", 32'h100, 20, 3, 7, 0, 0, 2'b00, 0, 1);
    // R4 narrow unaligned start with backpressure
    run("narrow_unaligned", 32'h203, 7, 1, 15, 1, 1, 2'b00, 0, 2);
    // R6 truncated by the beat ceiling
    run("ceiling_trunc", 32'h0, 40, 2, 3, 0, 1, 2'b00, 0, 3);
    // R9 unaligned full width, error response passed through
    run("unaligned_slverr", 32'h1005, 13, 3, 7, 1, 0, 2'b10, 0, 4);
    // R3 single byte at the top lane
    run("single_byte", 32'h7, 1, 0, 0, 0, 0, 2'b00, 0, 5);
    // R7 256-beat burst of single bytes
    run("max_beats", 32'h40, 300, 0, 255, 0, 0, 2'b00, 0, 6);
    // R10 zero count and oversized transfer
    run("reject_zero", 32'h10, 0, 2, 3, 0, 0, 2'b00, 1, 7);
    run("reject_size", 32'h10, 8, 4, 3, 0, 0, 2'b00, 1, 8);
    // R2 mid-size burst after refusals
    run("after_reject", 32'h33, 21, 2, 9, 1, 1, 2'b11, 0, 9);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule